// File: doc/BRIEF.md
# Calendar Time Counter Register Bank

This block is a memory-mapped calendar counter. It holds seven fields: second, minute, hour, day of week, day of month, month and a two-digit year. It advances by one second on each single-cycle pulse of its tick input. The tick comes from a prescaler outside the block, in the same clock domain. Software reaches the block over a simple 32-bit register bus. A write takes effect on a clock edge. A read is combinational from the address.

Counting is gated in two ways. A seven-write unlock sequence must first be completed, with each write carrying the correct key byte to its own key register. A stop bit in the control register must also be clear. Every carry caused by one tick lands in the same clock edge. Software can therefore read the seconds register, read the other fields, and read the seconds again. If the two seconds values match, the fields read in between are consistent.

Top module: `cal_counter_bank`

## Requirements
- R1: After reset every field reads 0, except month and day of month, which read 1. The control register reads 1 (stopped), the debounce field reads 0, and the block is locked.
- R2: The block counts only after seven writes have been made in sequence. Each write goes to one key register and its low byte must match that register's key. The key registers are, in order: 0x04 with 0xC6, 0x08 with 0x9A, 0x0C with 0x59, 0x10 with 0xA3, 0x14 with 0x57, 0x18 with 0x67, and 0x1C with 0xD2.
- R3: The block returns to the locked start state on three kinds of key-register write: a write with a wrong key byte, a write to the wrong key register, or any key-register write made while the block is already unlocked.
- R4: The control register at 0x20 holds the stop flag in bit 0. While the flag is 1, ticks are ignored. Writing 0 lets the next tick advance the calendar. All other bits of this register read 0.
- R5: The debounce setting at 0x2C is a 3-bit read/write field in bits 2:0, with the upper bits reading 0. It has no effect on counting.
- R6: The field registers sit at 0x40 + 4*k. From k=0 upward they are year, month, day of month, day of week, hour, minute and second. A write loads the field on the next edge, truncated to the field width, and causes no carry into any other field.
- R7: On a counted tick, seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0 and carry into the day.
- R8: The day of month rolls to 1 after the month's last day. April, June, September and November have 30 days; the other months except February have 31. Month 12 rolls to 1 and carries into the year.
- R9: February has 29 days when the year is nonzero and divisible by 4. Otherwise it has 28 days, and this includes year 0.
- R10: The year counts from 0 to 99 and wraps from 99 to 0.
- R11: The day of week advances by one on every day change and wraps from 6 to 0. It is left unchanged otherwise.
- R12: A field write that shares an edge with a tick is applied, and that tick is dropped for every field.
- R13: All field changes caused by one tick appear together on the clock edge where the tick is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse, once per second |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |

## Verification
Two things can land on the same edge: a bus write to a field register and a counted tick. The bench provokes this by raising the write strobe for the minute register in the very cycle that it pulses the tick, while the calendar is running and unlocked. Afterwards the minute field must hold the written value and the seconds must be unchanged. The following plain tick must then advance the seconds again.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int DataW    = 32;
  localparam int AddrW    = 8;
  localparam int YearW    = 7;
  localparam int MonW     = 4;
  localparam int DomW     = 5;
  localparam int DowW     = 3;
  localparam int HourW    = 5;
  localparam int MinW     = 6;
  localparam int SecW     = 6;
  localparam int FieldCnt = 7;
  localparam int KeyCount = 7;
  localparam int KeyStepW = $clog2(KeyCount + 1);
  localparam int DebW     = 3;

  localparam logic [AddrW-1:0] CtlAddr = 8'h20;
  localparam logic [AddrW-1:0] DebAddr = 8'h2C;

  typedef enum logic [2:0] {
    F_YEAR, F_MONTH, F_DOM, F_DOW, F_HOUR, F_MIN, F_SEC
  } fieldIdx_e;

  typedef struct packed {
    logic [YearW-1:0] year;
    logic [MonW-1:0]  month;
    logic [DomW-1:0]  dom;
    logic [DowW-1:0]  dow;
    logic [HourW-1:0] hour;
    logic [MinW-1:0]  min;
    logic [SecW-1:0]  sec;
  } calTime_t;

  typedef struct packed {
    logic [FieldCnt-1:0] fieldWe;
    logic [DataW-1:0]    wrVal;
    logic                advance;
  } calStrobe_t;

  function automatic logic [7:0] keyValue(input logic [KeyStepW-1:0] idx);
    case (idx)
      3'd0:    return 8'hC6;
      3'd1:    return 8'h9A;
      3'd2:    return 8'h59;
      3'd3:    return 8'hA3;
      3'd4:    return 8'h57;
      3'd5:    return 8'h67;
      default: return 8'hD2;
    endcase
  endfunction

  function automatic logic [DomW-1:0] monthLength(input logic [MonW-1:0] month,
                                                  input logic [YearW-1:0] year);
    case (month)
      4'd4, 4'd6, 4'd9, 4'd11: return DomW'(30);
      4'd2: return (year != '0 && year[1:0] == 2'b00) ? DomW'(29) : DomW'(28);
      default: return DomW'(31);
    endcase
  endfunction
endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             secTick,
  input  logic             busWe,
  input  logic [AddrW-1:0] busAddr,
  input  logic [DataW-1:0] busWdata,
  input  calTime_t         curTime,
  output calStrobe_t       strobe,
  output logic [DataW-1:0] busRdata
);
  logic [KeyStepW-1:0] keyStep;
  logic                stopBit;
  logic [DebW-1:0]     debounce;
  logic                isKeyAddr, isFieldAddr, unlocked;
  logic [KeyStepW-1:0] keyIdx;

  assign isKeyAddr   = busAddr[7:5] == 3'b000 && busAddr[1:0] == 2'b00 && busAddr[4:2] != 3'd0;
  assign isFieldAddr = busAddr[7:5] == 3'b010 && busAddr[1:0] == 2'b00 && busAddr[4:2] != 3'd7;
  assign keyIdx      = busAddr[4:2] - 3'd1;
  assign unlocked    = keyStep == KeyStepW'(KeyCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyStep  <= '0;
      stopBit  <= 1'b1;
      debounce <= '0;
    end else if (busWe) begin
      if (isKeyAddr) begin
        if (!unlocked && keyIdx == keyStep && busWdata[7:0] == keyValue(keyStep))
          keyStep <= keyStep + 1'b1;
        else
          keyStep <= '0;
      end
      if (busAddr == CtlAddr) stopBit  <= busWdata[0];
      if (busAddr == DebAddr) debounce <= busWdata[DebW-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < FieldCnt; i++)
      strobe.fieldWe[i] = busWe && isFieldAddr && busAddr[4:2] == 3'(i);
    strobe.wrVal   = busWdata;
    strobe.advance = secTick && unlocked && !stopBit && !(|strobe.fieldWe);
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == CtlAddr)      busRdata = DataW'(stopBit);
    else if (busAddr == DebAddr) busRdata = DataW'(debounce);
    else if (isFieldAddr) begin
      case (busAddr[4:2])
        3'd0:    busRdata = DataW'(curTime.year);
        3'd1:    busRdata = DataW'(curTime.month);
        3'd2:    busRdata = DataW'(curTime.dom);
        3'd3:    busRdata = DataW'(curTime.dow);
        3'd4:    busRdata = DataW'(curTime.hour);
        3'd5:    busRdata = DataW'(curTime.min);
        default: busRdata = DataW'(curTime.sec);
      endcase
    end
  end

  AST_DEB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr == DebAddr) |=> $stable(debounce)); // R5
  AST_KEY_BUS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> $stable(keyStep)); // R3
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int YearMax = 99
) (
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strobe,
  output calTime_t   curTime
);
  calTime_t nxt;
  logic secWrap, minWrap, hourWrap, domWrap, monWrap, yearWrap;
  logic toMin, toHour, toDay, toMon, toYear;
  logic unusedWrBits;

  assign unusedWrBits = ^strobe.wrVal[DataW-1:YearW];

  always_comb begin
    secWrap  = curTime.sec  >= SecW'(59);
    minWrap  = curTime.min  >= MinW'(59);
    hourWrap = curTime.hour >= HourW'(23);
    domWrap  = curTime.dom  >= monthLength(curTime.month, curTime.year);
    monWrap  = curTime.month >= MonW'(12);
    yearWrap = curTime.year >= YearW'(YearMax);
    toMin  = secWrap;
    toHour = toMin && minWrap;
    toDay  = toHour && hourWrap;
    toMon  = toDay && domWrap;
    toYear = toMon && monWrap;
    nxt.sec   = secWrap ? '0 : curTime.sec + 1'b1;
    nxt.min   = !toMin  ? curTime.min  : (minWrap  ? '0 : curTime.min + 1'b1);
    nxt.hour  = !toHour ? curTime.hour : (hourWrap ? '0 : curTime.hour + 1'b1);
    nxt.dow   = !toDay  ? curTime.dow  : (curTime.dow >= DowW'(6) ? '0 : curTime.dow + 1'b1);
    nxt.dom   = !toDay  ? curTime.dom  : (domWrap  ? DomW'(1) : curTime.dom + 1'b1);
    nxt.month = !toMon  ? curTime.month : (monWrap ? MonW'(1) : curTime.month + 1'b1);
    nxt.year  = !toYear ? curTime.year : (yearWrap ? '0 : curTime.year + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTime.year  <= '0;
      curTime.month <= MonW'(1);
      curTime.dom   <= DomW'(1);
      curTime.dow   <= '0;
      curTime.hour  <= '0;
      curTime.min   <= '0;
      curTime.sec   <= '0;
    end else if (|strobe.fieldWe) begin
      if (strobe.fieldWe[F_YEAR])  curTime.year  <= strobe.wrVal[YearW-1:0];
      if (strobe.fieldWe[F_MONTH]) curTime.month <= strobe.wrVal[MonW-1:0];
      if (strobe.fieldWe[F_DOM])   curTime.dom   <= strobe.wrVal[DomW-1:0];
      if (strobe.fieldWe[F_DOW])   curTime.dow   <= strobe.wrVal[DowW-1:0];
      if (strobe.fieldWe[F_HOUR])  curTime.hour  <= strobe.wrVal[HourW-1:0];
      if (strobe.fieldWe[F_MIN])   curTime.min   <= strobe.wrVal[MinW-1:0];
      if (strobe.fieldWe[F_SEC])   curTime.sec   <= strobe.wrVal[SecW-1:0];
    end else if (strobe.advance) begin
      curTime <= nxt;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && strobe.fieldWe == '0) |=> $stable(curTime)); // R4
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> curTime.sec == (($past(curTime.sec) >= SecW'(59)) ? SecW'(0)
                                       : SecW'($past(curTime.sec) + 1'b1))); // R7
  AST_FIELD_WR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fieldWe[F_SEC] |=> curTime.sec == $past(strobe.wrVal[SecW-1:0])); // R6
  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && curTime.year == YearW'(YearMax) && curTime.month == MonW'(12) &&
     curTime.dom == DomW'(31) && curTime.hour == HourW'(23) && curTime.min == MinW'(59) &&
     curTime.sec == SecW'(59)) |=> curTime.year == '0); // R10
  AST_DOW_DAY_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && curTime.hour != HourW'(23)) |=> $stable(curTime.dow)); // R11
endmodule

// File: rtl/cal_counter_bank.sv
module cal_counter_bank
  import cal_pkg::*;
#(
  parameter int YearMax = 99
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        secTick,
  input  logic        busWe,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata
);
  calStrobe_t strobe;
  calTime_t   curTime;

  cal_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .curTime(curTime),
    .strobe(strobe), .busRdata(busRdata)
  );

  cal_datapath #(.YearMax(YearMax)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curTime(curTime)
  );
endmodule

// File: tb/cal_counter_bank_bench.sv
module cal_counter_bank_bench;
  localparam int ClkPeriod = 10;
  localparam logic [7:0] KeyVals [7] = '{8'hC6, 8'h9A, 8'h59, 8'hA3, 8'h57, 8'h67, 8'hD2};

  logic clk = 0, rstN = 0, secTick = 0, busWe = 0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  cal_counter_bank u_cal_counter_bank (.clk(clk), .rstN(rstN), .secTick(secTick),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata));

  always #(ClkPeriod/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk); busWe = 0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    busAddr = a; #1;
    check(req, busRdata, exp);
  endtask

  task automatic tick();
    @(negedge clk); secTick = 1;
    @(negedge clk); secTick = 0;
  endtask

  task automatic setTime(input int y, mo, d, w, h, mi, s);
    wr(8'h40, y); wr(8'h44, mo); wr(8'h48, d); wr(8'h4C, w);
    wr(8'h50, h); wr(8'h54, mi); wr(8'h58, s);
  endtask

  task automatic expTime(input string req, input int y, mo, d, w, h, mi, s);
    rdChk({req, " year"}, 8'h40, y);  rdChk({req, " month"}, 8'h44, mo);
    rdChk({req, " dom"}, 8'h48, d);   rdChk({req, " dow"}, 8'h4C, w);
    rdChk({req, " hour"}, 8'h50, h);  rdChk({req, " min"}, 8'h54, mi);
    rdChk({req, " sec"}, 8'h58, s);
  endtask

  task automatic unlockSteps(input int n);
    for (int i = 0; i < n; i++) wr(8'h04 + 8'(4*i), {24'h0, KeyVals[i]});
  endtask

  task automatic t_reset();
    expTime("R1", 0, 1, 1, 0, 0, 0, 0);
    rdChk("R1 ctl", 8'h20, 1);
    rdChk("R1 deb", 8'h2C, 0);
    wr(8'h20, 0); tick();
    rdChk("R1 locked", 8'h58, 0);
  endtask

  task automatic t_unlock();
    unlockSteps(6); tick();
    rdChk("R2 six keys", 8'h58, 0);
    wr(8'h1C, 32'hD2); tick();
    rdChk("R2 seven keys", 8'h58, 1);
  endtask

  task automatic t_relock();
    wr(8'h04, 32'hC6); tick();
    rdChk("R3 write while unlocked", 8'h58, 1);
    unlockSteps(3); wr(8'h10, 32'h00);
    wr(8'h10, 32'hA3); wr(8'h14, 32'h57); wr(8'h18, 32'h67); wr(8'h1C, 32'hD2); tick();
    rdChk("R3 wrong value", 8'h58, 1);
    unlockSteps(2); wr(8'h10, 32'hA3); wr(8'h0C, 32'h59);
    wr(8'h14, 32'h57); wr(8'h18, 32'h67); wr(8'h1C, 32'hD2); tick();
    rdChk("R3 out of order", 8'h58, 1);
    unlockSteps(7); tick();
    rdChk("R3 relock then unlock", 8'h58, 2);
  endtask

  task automatic t_stop();
    wr(8'h20, 32'hFFFF_FFFF);
    rdChk("R4 ctl reads 1", 8'h20, 1);
    tick(); tick();
    rdChk("R4 stopped", 8'h58, 2);
    wr(8'h20, 0); tick();
    rdChk("R4 resumed", 8'h58, 3);
  endtask

  task automatic t_debounce();
    wr(8'h2C, 32'hFFFF_FFFD);
    rdChk("R5 deb value", 8'h2C, 5);
    tick();
    rdChk("R5 counting unaffected", 8'h58, 4);
  endtask

  task automatic t_fields();
    wr(8'h20, 1);
    setTime(42, 7, 15, 3, 9, 30, 59);
    expTime("R6 readback", 42, 7, 15, 3, 9, 30, 59);
    wr(8'h58, 32'hFFFF_FFC5);
    rdChk("R6 truncate sec", 8'h58, 5);
    rdChk("R6 no carry", 8'h54, 30);
    wr(8'h20, 0);
  endtask

  task automatic t_rollover();
    setTime(98, 12, 31, 6, 23, 59, 59); tick();
    expTime("R13 R7 R8 R11 new year", 99, 1, 1, 0, 0, 0, 0);
    setTime(99, 12, 31, 2, 23, 59, 59); tick();
    expTime("R10 year wrap", 0, 1, 1, 3, 0, 0, 0);
    setTime(10, 4, 30, 5, 23, 59, 59); tick();
    expTime("R8 april", 10, 5, 1, 6, 0, 0, 0);
    setTime(10, 5, 30, 1, 23, 59, 59); tick();
    expTime("R8 may 30", 10, 5, 31, 2, 0, 0, 0);
    setTime(10, 6, 1, 1, 7, 59, 59); tick();
    expTime("R7 hour carry", 10, 6, 1, 1, 8, 0, 0);
  endtask

  task automatic t_leap();
    setTime(4, 2, 28, 2, 23, 59, 59); tick();
    expTime("R9 leap 29th", 4, 2, 29, 3, 0, 0, 0);
    wr(8'h50, 23); wr(8'h54, 59); wr(8'h58, 59); tick();
    expTime("R9 leap to march", 4, 3, 1, 4, 0, 0, 0);
    setTime(0, 2, 28, 0, 23, 59, 59); tick();
    expTime("R9 year zero", 0, 3, 1, 1, 0, 0, 0);
    setTime(5, 2, 28, 0, 23, 59, 59); tick();
    expTime("R9 odd year", 5, 3, 1, 1, 0, 0, 0);
  endtask

  task automatic t_collide();
    setTime(20, 8, 10, 4, 10, 20, 30);
    @(negedge clk); busWe = 1; busAddr = 8'h54; busWdata = 45; secTick = 1;
    @(negedge clk); busWe = 0; secTick = 0;
    rdChk("R12 written min", 8'h54, 45);
    rdChk("R12 tick dropped", 8'h58, 30);
    tick();
    rdChk("R12 next tick", 8'h58, 31);
  endtask

  initial begin
    #(ClkPeriod * 100000);
    nFails++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_unlock();
    t_relock();
    t_stop();
    t_debounce();
    t_fields();
    t_rollover();
    t_leap();
    t_collide();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule